// File: doc/BRIEF.md
# PCI Parity and System Error Reporter

This block is the error-signalling logic of a host bridge that sits between a processor, main memory and a PCI bus. It takes single-cycle error detections from the bridge datapath: a parity fault in a PCI address phase, a data parity fault on a processor read from PCI, a data parity fault on a PCI-master write into memory, the processor's parity-check indication on reads from DRAM or from the second-level cache, and a target abort on a cycle the bridge started. It turns them into the active-low PERR# and SERR# pulses.

Two levels of enables decide what reaches the pins. A global parity-enable bit from the PCI command register gates everything. Per-source bits from the error command register then pick which faults raise SERR#. PERR# handling has its own enable, which works only together with the global bit. When PERR# handling is on, the block also watches PERR# from the target a fixed number of clocks after it drives processor write data. A target-reported fault found this way is one more SERR# source. Each SERR# source also has a sticky status bit that software clears by writing 1.

Top module: `pci_err_reporter`

## Requirements
- R1: After reset, `perr_oe`, `serr_oe` and every bit of `status` are 0.
- R2: PERR# handling is active only when `cfg_par_en` and `cfg_perr_rx_en` are both 1. While it is inactive, PERR# is never driven low and PERR# from targets is never sampled: no status bit 2 and no SERR# come from it.
- R3: With PERR# handling active, `perr_in_n` is sampled exactly `SAMPLE_DLY` clocks after a clock in which `wr_data_drive` is 1 (default 2). A low level there counts as a transmitted-data fault. A low level in any other clock is ignored.
- R4: With PERR# handling active, `ev_rd_data_par` or `ev_mst_wr_par` in clock t makes the bridge drive PERR# as follows. In clock t+1, `perr_oe`=1 and `perr_out_n`=0. In clock t+2, `perr_oe`=1 and `perr_out_n`=1. From clock t+3, `perr_oe`=0, unless a new event restarts the pulse.
- R5: While `cfg_par_en` is 0, `serr_oe` stays 0 whatever the other enables and events are.
- R6: A processor-read DRAM parity fault (`ev_pchk_dram`) raises SERR# when `cfg_serr_mem_en` is 1.
- R7: A processor-read second-level cache parity fault (`ev_pchk_l2`) raises SERR# only when `cfg_serr_mem_en` and `cfg_serr_l2_en` are both 1.
- R8: A PCI-master address-phase parity fault (`ev_addr_par`) raises SERR# when `cfg_serr_addr_en` is 1.
- R9: A data parity fault on a processor read from PCI (`ev_rd_data_par`) raises SERR# when `cfg_serr_rxd_en` is 1.
- R10: A transmitted-data fault found by R3 raises SERR# when `cfg_serr_txd_en` is 1.
- R11: A target abort on a bridge-initiated cycle (`ev_tabort`) raises SERR# when `cfg_serr_tab_en` is 1.
- R12: SERR# is open-drain. `serr_oe`=1 means the pin is pulled low. It is high for one clock, the clock after the qualifying event. Any number of events in the same clock give one single-clock pulse.
- R13: `status` bits are set, one clock after detection and regardless of the SERR# enables: bit 0 address fault, bit 1 received data fault, bit 2 transmitted data fault, bit 3 target abort, bit 4 DRAM fault, bit 5 L2 fault. A bit stays set until a clock with its `status_clr` bit at 1. A new detection in that same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_par_en | input | 1 | Global parity enable (command register) |
| cfg_perr_rx_en | input | 1 | PERR# handling enable |
| cfg_serr_mem_en | input | 1 | SERR# on DRAM/L2 read parity |
| cfg_serr_l2_en | input | 1 | Extra enable for L2 read parity |
| cfg_serr_addr_en | input | 1 | SERR# on address-phase parity |
| cfg_serr_rxd_en | input | 1 | SERR# on received data parity |
| cfg_serr_txd_en | input | 1 | SERR# on transmitted data parity |
| cfg_serr_tab_en | input | 1 | SERR# on received target abort |
| ev_addr_par | input | 1 | Address-phase parity fault, PCI master cycle |
| ev_rd_data_par | input | 1 | Data parity fault, processor read from PCI |
| ev_mst_wr_par | input | 1 | Data parity fault, PCI-master write to memory |
| ev_pchk_dram | input | 1 | Processor parity check, DRAM read |
| ev_pchk_l2 | input | 1 | Processor parity check, L2 read |
| ev_tabort | input | 1 | Target abort on bridge-initiated cycle |
| wr_data_drive | input | 1 | Bridge drives processor write data this clock |
| perr_in_n | input | 1 | PERR# pin as seen on the bus |
| perr_out_n | output | 1 | PERR# value driven when enabled |
| perr_oe | output | 1 | PERR# output enable |
| serr_oe | output | 1 | SERR# pull-down enable |
| status | output | 6 | Sticky per-source error flags |
| status_clr | input | 6 | Write-1-to-clear strobes for `status` |

## Verification
The bench keeps the default `SAMPLE_DLY` of 2, so the whole enable space fits in a sweep. It covers all 256 settings of the eight enable bits, and under each setting it raises every single source, including a master-write fault and a full target-PERR# write sequence. At that delay it can also place target PERR# one clock early and one clock late to show the sampling window is exact. Directed cases then cover simultaneous events, a clear that meets a new detection, and PERR# pulses back to back.

// File: rtl/pci_err_pkg.sv
package pci_err_pkg;
  localparam int NSRC     = 6;
  localparam int SRC_ADDR = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TXD  = 2;
  localparam int SRC_TAB  = 3;
  localparam int SRC_DRAM = 4;
  localparam int SRC_L2   = 5;

  typedef struct packed {
    logic par_en;
    logic perr_rx_en;
    logic serr_mem_en;
    logic serr_l2_en;
    logic serr_addr_en;
    logic serr_rxd_en;
    logic serr_txd_en;
    logic serr_tab_en;
  } err_cfg_t;

  // PERR# is handled only under both enables
  function automatic logic perr_active(err_cfg_t c);
    return c.par_en & c.perr_rx_en;
  endfunction

  // Per-source SERR# qualification; L2 needs two enables
  function automatic logic [NSRC-1:0] serr_gate(logic [NSRC-1:0] ev, err_cfg_t c);
    logic [NSRC-1:0] en;
    en[SRC_ADDR] = c.serr_addr_en;
    en[SRC_RXD]  = c.serr_rxd_en;
    en[SRC_TXD]  = c.serr_txd_en;
    en[SRC_TAB]  = c.serr_tab_en;
    en[SRC_DRAM] = c.serr_mem_en;
    en[SRC_L2]   = c.serr_mem_en & c.serr_l2_en;
    return c.par_en ? (ev & en) : '0;
  endfunction
endpackage

// File: rtl/perr_sampler.sv
module perr_sampler #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wr_drive,
  input  logic perr_in_n,
  output logic tx_hit
);
  logic [DLY-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= (pipe << 1) | DLY'(wr_drive);
  end

  assign tx_hit = active & pipe[DLY-1] & ~perr_in_n;
endmodule

// File: rtl/perr_driver.sv
module perr_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic out_n,
  output logic oe
);
  typedef enum logic [1:0] {PD_IDLE, PD_LOW, PD_HIGH} pd_state_t;
  pd_state_t st;

  always_ff @(posedge clk) begin
    if (!rst_n)            st <= PD_IDLE;
    else if (req)          st <= PD_LOW;
    else if (st == PD_LOW) st <= PD_HIGH;
    else                   st <= PD_IDLE;
  end

  assign out_n = (st != PD_LOW);
  assign oe    = (st != PD_IDLE);
endmodule

// File: rtl/serr_collector.sv
module serr_collector #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] det,
  input  logic [N-1:0] clr,
  output logic         serr_oe,
  output logic [N-1:0] status
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serr_oe <= 1'b0;
      status  <= '0;
    end else begin
      serr_oe <= |hit;
      status  <= (status & ~clr) | det;
    end
  end
endmodule

// File: rtl/pci_err_reporter.sv
module pci_err_reporter
  import pci_err_pkg::*;
#(
  parameter int SAMPLE_DLY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_par_en,
  input  logic            cfg_perr_rx_en,
  input  logic            cfg_serr_mem_en,
  input  logic            cfg_serr_l2_en,
  input  logic            cfg_serr_addr_en,
  input  logic            cfg_serr_rxd_en,
  input  logic            cfg_serr_txd_en,
  input  logic            cfg_serr_tab_en,
  input  logic            ev_addr_par,
  input  logic            ev_rd_data_par,
  input  logic            ev_mst_wr_par,
  input  logic            ev_pchk_dram,
  input  logic            ev_pchk_l2,
  input  logic            ev_tabort,
  input  logic            wr_data_drive,
  input  logic            perr_in_n,
  output logic            perr_out_n,
  output logic            perr_oe,
  output logic            serr_oe,
  output logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] status_clr
);
  err_cfg_t        cfg;
  logic            perr_act;
  logic            perr_req;
  logic            tx_hit;
  logic [NSRC-1:0] src_det;
  logic [NSRC-1:0] serr_hit;

  assign cfg = '{par_en: cfg_par_en, perr_rx_en: cfg_perr_rx_en,
                 serr_mem_en: cfg_serr_mem_en, serr_l2_en: cfg_serr_l2_en,
                 serr_addr_en: cfg_serr_addr_en, serr_rxd_en: cfg_serr_rxd_en,
                 serr_txd_en: cfg_serr_txd_en, serr_tab_en: cfg_serr_tab_en};

  assign perr_act = perr_active(cfg);
  assign perr_req = perr_act & (ev_rd_data_par | ev_mst_wr_par);

  always_comb begin
    src_det           = '0;
    src_det[SRC_ADDR] = ev_addr_par;
    src_det[SRC_RXD]  = ev_rd_data_par;
    src_det[SRC_TXD]  = tx_hit;
    src_det[SRC_TAB]  = ev_tabort;
    src_det[SRC_DRAM] = ev_pchk_dram;
    src_det[SRC_L2]   = ev_pchk_l2;
  end

  assign serr_hit = serr_gate(src_det, cfg);

  perr_sampler #(.DLY(SAMPLE_DLY)) u_smp (
    .clk(clk), .rst_n(rst_n), .active(perr_act), .wr_drive(wr_data_drive),
    .perr_in_n(perr_in_n), .tx_hit(tx_hit));

  perr_driver u_pdrv (
    .clk(clk), .rst_n(rst_n), .req(perr_req), .out_n(perr_out_n), .oe(perr_oe));

  serr_collector #(.N(NSRC)) u_serr (
    .clk(clk), .rst_n(rst_n), .hit(serr_hit), .det(src_det), .clr(status_clr),
    .serr_oe(serr_oe), .status(status));
endmodule

// File: rtl/pci_err_reporter_chk.sv
module pci_err_reporter_chk #(
  parameter int N = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_par_en,
  input logic         perr_act,
  input logic         perr_req,
  input logic         tx_hit,
  input logic         perr_in_n,
  input logic [N-1:0] serr_hit,
  input logic         perr_out_n,
  input logic         perr_oe,
  input logic         serr_oe,
  input logic [N-1:0] status,
  input logic [N-1:0] status_clr
);
  assert_perr_low_from_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_out_n) |-> $past(perr_req));
  assert_perr_high_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && !perr_out_n) |=> perr_oe);
  assert_perr_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_oe && perr_out_n) |=> (!perr_oe || !perr_out_n));
  assert_no_perr_inactive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(perr_act) |-> !(perr_oe && !perr_out_n));
  assert_tx_sample_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hit |-> (perr_act && !perr_in_n));
  assert_serr_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_par_en) |-> !serr_oe);
  assert_serr_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    serr_oe |-> $past(|serr_hit));
  assert_status_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~$past(status_clr)) & ~status) == '0);
endmodule

bind pci_err_reporter pci_err_reporter_chk #(.N(pci_err_pkg::NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .perr_act(perr_act),
  .perr_req(perr_req), .tx_hit(tx_hit), .perr_in_n(perr_in_n),
  .serr_hit(serr_hit), .perr_out_n(perr_out_n), .perr_oe(perr_oe),
  .serr_oe(serr_oe), .status(status), .status_clr(status_clr));

// File: tb/tb_pci_err_reporter.sv
module tb_pci_err_reporter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg = '0;   // [0]par [1]perr_rx [2]mem [3]l2 [4]addr [5]rxd [6]txd [7]tab
  logic e_addr = 0, e_rxd = 0, e_mwr = 0, e_dram = 0, e_l2 = 0, e_tab = 0;
  logic wdd = 0, pin_n = 1;
  logic [5:0] clr = '0;
  logic perr_out_n, perr_oe, serr_oe;
  logic [5:0] status;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  pci_err_reporter dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_par_en(cfg[0]), .cfg_perr_rx_en(cfg[1]), .cfg_serr_mem_en(cfg[2]),
    .cfg_serr_l2_en(cfg[3]), .cfg_serr_addr_en(cfg[4]), .cfg_serr_rxd_en(cfg[5]),
    .cfg_serr_txd_en(cfg[6]), .cfg_serr_tab_en(cfg[7]),
    .ev_addr_par(e_addr), .ev_rd_data_par(e_rxd), .ev_mst_wr_par(e_mwr),
    .ev_pchk_dram(e_dram), .ev_pchk_l2(e_l2), .ev_tabort(e_tab),
    .wr_data_drive(wdd), .perr_in_n(pin_n),
    .perr_out_n(perr_out_n), .perr_oe(perr_oe), .serr_oe(serr_oe),
    .status(status), .status_clr(clr));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ev(input int s, input logic v);
    case (s)
      0: e_addr = v;
      1: e_rxd  = v;
      3: e_tab  = v;
      4: e_dram = v;
      5: e_l2   = v;
      6: e_mwr  = v;
      default: ;
    endcase
  endtask

  task automatic clear_all();
    clr = '1; @(negedge clk); clr = '0; @(negedge clk);
  endtask

  // target PERR# low at 'lag' clocks after write data
  task automatic tx_seq(input int lag);
    wdd = 1; @(negedge clk); wdd = 0;
    for (int k = 1; k < lag; k++) @(negedge clk);
    pin_n = 0; @(negedge clk); pin_n = 1;
  endtask

  function automatic logic exp_serr(input int s, input logic [7:0] c);
    logic pa = c[0] & c[1];
    case (s)
      0: return c[0] & c[4];            // R8
      1: return c[0] & c[5];            // R9
      2: return c[0] & pa & c[6];       // R10
      3: return c[0] & c[7];            // R11
      4: return c[0] & c[2];            // R6
      5: return c[0] & c[2] & c[3];     // R7
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic pa, eperr;
    repeat (3) @(negedge clk);
    chk("R1 perr_oe", {7'd0, perr_oe}, 8'd0);
    chk("R1 serr_oe", {7'd0, serr_oe}, 8'd0);
    chk("R1 status", {2'd0, status}, 8'd0);
    rst_n = 1; @(negedge clk);

    for (int c = 0; c < 256; c++) begin
      cfg = c[7:0]; @(negedge clk);
      pa = cfg[0] & cfg[1];
      for (int s = 0; s < 7; s++) begin
        if (s == 2) tx_seq(2);
        else begin set_ev(s, 1); @(negedge clk); set_ev(s, 0); end
        // one clock after the event
        chk(s == 2 ? "R10 serr" : (s == 6 ? "R5 serr" : "R6-R11 serr"),
            {7'd0, serr_oe}, {7'd0, exp_serr(s, cfg)});
        if (s < 6)
          chk(s == 2 ? "R3 status" : "R13 status", {7'd0, status[s]},
              {7'd0, (s == 2) ? pa : 1'b1});
        eperr = (s == 1 || s == 6) && pa;
        chk("R4 perr low", {6'd0, perr_oe, perr_out_n}, eperr ? 8'h2 : 8'h1 & {7'd0, perr_out_n});
        @(negedge clk);
        chk("R12 serr single", {7'd0, serr_oe}, 8'd0);
        chk("R4 perr high", {6'd0, perr_oe, perr_out_n}, eperr ? 8'h3 : {7'd0, perr_out_n});
        @(negedge clk);
        chk("R4 perr release", {7'd0, perr_oe}, 8'd0);
        clear_all();
        chk("R13 cleared", {2'd0, status}, 8'd0);
      end
    end

    // R3: PERR# outside the sample clock is ignored
    cfg = 8'hFF; @(negedge clk);
    tx_seq(1); @(negedge clk);
    chk("R3 early ignored", {1'b0, serr_oe, status}, 8'd0);
    tx_seq(3);
    chk("R3 late ignored", {1'b0, serr_oe, status}, 8'd0);
    // R2: sampling off when PERR handling disabled
    cfg = 8'hFD; @(negedge clk);
    tx_seq(2);
    chk("R2 no sample", {1'b0, serr_oe, status}, 8'd0);
    cfg = 8'hFF; @(negedge clk);

    // R12: all sources at once give one pulse
    e_addr = 1; e_rxd = 1; e_tab = 1; e_dram = 1; e_l2 = 1;
    @(negedge clk);
    e_addr = 0; e_rxd = 0; e_tab = 0; e_dram = 0; e_l2 = 0;
    chk("R12 multi pulse", {7'd0, serr_oe}, 8'd1);
    chk("R13 multi status", {2'd0, status}, 8'h3B);
    @(negedge clk);
    chk("R12 multi single", {7'd0, serr_oe}, 8'd0);
    clear_all();

    // R13: set wins over clear in same clock
    e_tab = 1; @(negedge clk); e_tab = 0; @(negedge clk);
    e_tab = 1; clr = 6'h08; @(negedge clk); e_tab = 0; clr = 0;
    chk("R13 set beats clear", {7'd0, status[3]}, 8'd1);
    clr = 6'h08; @(negedge clk); clr = 0;
    chk("R13 w1c", {7'd0, status[3]}, 8'd0);

    // R4: back-to-back PERR# events restart the pulse
    e_mwr = 1; @(negedge clk); @(negedge clk); e_mwr = 0;
    chk("R4 b2b low", {6'd0, perr_oe, perr_out_n}, 8'h2);
    @(negedge clk);
    chk("R4 b2b high", {6'd0, perr_oe, perr_out_n}, 8'h3);
    @(negedge clk);
    chk("R4 b2b release", {7'd0, perr_oe}, 8'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule